// File: doc/BRIEF.md
# Packed 3x3 Binary Erosion and Dilation Engine

This block applies a 3x3 morphological minimum (erosion) or maximum (dilation) to a one-bit-per-pixel image. The image is packed so that one data word holds `W` horizontally adjacent pixels. On each accepted beat the engine takes one word from each of three vertically adjacent rows, all at the same column position, and returns one result word for the middle row. For one-bit pixels the window minimum is a 9-input AND and the window maximum is a 9-input OR. All `W` output pixels are formed in parallel by shifting the packed rows against each other.

Each row contributes one extra pixel on each side of the word. These pixels are the edge bits of the neighbouring words and arrive on separate neighbour inputs. Four edge flags mark image borders. At a border, the missing pixels are replaced by the neutral value of the current operation: 1 for erosion and 0 for dilation. A surrounding controller that holds the row buffers streams word triples in. It runs an opening by passing the image once in erosion mode and then once in dilation mode. The operation is chosen per beat. The engine accepts a beat every cycle and answers after a fixed two cycles.

Top module: `bmorph_engine`

## Requirements
- R1: With `in_dilate`=0, output bit k is the AND of the nine pixels in rows up/mid/down at columns k-1, k, k+1.
- R2: With `in_dilate`=1, output bit k is the OR of the same nine pixels.
- R3: Bit 0 of every word is the leftmost pixel. Column -1 of row r is `nbr_left[r]` and column W is `nbr_right[r]`, with r=0 for the up row, 1 for the middle row and 2 for the down row.
- R4: When `at_left`=1, `nbr_left` has no effect. Column -1 of every row reads as 1 in erosion and 0 in dilation.
- R5: When `at_right`=1, `nbr_right` has no effect. Column W of every row reads as 1 in erosion and 0 in dilation.
- R6: When `at_top`=1, the up row is replaced, including its neighbour bits, by all 1 in erosion and all 0 in dilation. `at_bottom` does the same for the down row.
- R7: A beat presented with `in_valid`=1 produces `out_valid`=1 and its result exactly two cycles later. Beats may arrive every cycle, and each beat carries its own mode.
- R8: In a cycle with `out_valid`=0, `out_word` keeps the last result.
- R9: `out_valid` is 0 while `rst_n` is low, and it stays 0 after release until a beat has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| in_valid | input | 1 | Beat present on the inputs |
| in_dilate | input | 1 | 1 = dilation (OR), 0 = erosion (AND) |
| row_up | input | W | Word of the row above |
| row_mid | input | W | Word of the row being produced |
| row_dn | input | W | Word of the row below |
| nbr_left | input | 3 | Pixel left of bit 0 for up, mid and down rows |
| nbr_right | input | 3 | Pixel right of bit W-1 for up, mid and down rows |
| at_left | input | 1 | Word touches the left image border |
| at_right | input | 1 | Word touches the right image border |
| at_top | input | 1 | Middle row is the top image row |
| at_bottom | input | 1 | Middle row is the bottom image row |
| out_valid | output | 1 | Result word present |
| out_word | output | W | Result word for the middle row |

## Verification
The properties count cycles from the internally synchronised reset release. This means the latency and containment checks assume that beats offered during the two synchroniser cycles are dropped. The stimulus keeps `in_valid` low for several cycles after releasing reset. The containment properties (erosion output inside the middle row, dilation output covering it) depend only on the centre pixel always belonging to its own window, so they hold for any edge flags. The bench sweeps every combination of three 4-pixel rows in both modes. Neighbour bits and border flags are scrambled from the sweep index, and idle gaps are inserted so that the hold behaviour is observed between beats.

// File: rtl/bmorph_pkg.sv
package bmorph_pkg;

  typedef enum logic {
    OP_ERODE  = 1'b0,
    OP_DILATE = 1'b1
  } morph_op_e;

  localparam int unsigned WIN_ROWS = 3;

  // neutral element of the reduction: 1 for AND, 0 for OR
  function automatic logic pad_value(input morph_op_e op);
    return (op == OP_ERODE);
  endfunction

endpackage

// File: rtl/bmorph_row_extend.sv
module bmorph_row_extend #(
  parameter int unsigned W = 32
) (
  input  logic         left_px_i,
  input  logic         right_px_i,
  input  logic [W-1:0] word_i,
  input  logic         left_edge_i,
  input  logic         right_edge_i,
  input  logic         row_void_i,
  input  logic         pad_i,
  output logic [W+1:0] ext_o
);

  // ext_o[0] is column -1, ext_o[W+1] is column W
  always_comb begin
    ext_o[0]   = left_edge_i  ? pad_i : left_px_i;
    ext_o[W+1] = right_edge_i ? pad_i : right_px_i;
    ext_o[W:1] = word_i;
    if (row_void_i) begin
      ext_o = {(W+2){pad_i}};
    end
  end

endmodule

// File: rtl/bmorph_vreduce.sv
module bmorph_vreduce
  import bmorph_pkg::*;
#(
  parameter int unsigned N = 34
) (
  input  morph_op_e      op_i,
  input  logic [N-1:0]   up_i,
  input  logic [N-1:0]   mid_i,
  input  logic [N-1:0]   dn_i,
  output logic [N-1:0]   col_o
);

  for (genvar k = 0; k < N; k++) begin : g_col
    assign col_o[k] = (op_i == OP_DILATE) ? (up_i[k] | mid_i[k] | dn_i[k])
                                          : (up_i[k] & mid_i[k] & dn_i[k]);
  end

endmodule

// File: rtl/bmorph_hreduce.sv
module bmorph_hreduce
  import bmorph_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  morph_op_e      op_i,
  input  logic [W+1:0]   col_i,
  output logic [W-1:0]   px_o
);

  for (genvar k = 0; k < W; k++) begin : g_px
    logic [2:0] span;
    assign span    = col_i[k+2:k];
    assign px_o[k] = (op_i == OP_DILATE) ? (|span) : (&span);
  end

endmodule

// File: rtl/bmorph_engine.sv
module bmorph_engine
  import bmorph_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_dilate,
  input  logic [W-1:0] row_up,
  input  logic [W-1:0] row_mid,
  input  logic [W-1:0] row_dn,
  input  logic [2:0]   nbr_left,
  input  logic [2:0]   nbr_right,
  input  logic         at_left,
  input  logic         at_right,
  input  logic         at_top,
  input  logic         at_bottom,
  output logic         out_valid,
  output logic [W-1:0] out_word
);

  localparam int unsigned EW = W + 2;

  // ---------------- reset release synchroniser ----------------
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // ---------------- stage 0: border fill and vertical reduce ----------------
  morph_op_e    op0;
  logic         pad0;
  logic [W-1:0] rows    [WIN_ROWS];
  logic         row_void[WIN_ROWS];
  logic [EW-1:0] ext    [WIN_ROWS];
  logic [EW-1:0] col0;

  assign op0  = morph_op_e'(in_dilate);
  assign pad0 = pad_value(op0);

  assign rows[0]     = row_up;
  assign rows[1]     = row_mid;
  assign rows[2]     = row_dn;
  assign row_void[0] = at_top;
  assign row_void[1] = 1'b0;
  assign row_void[2] = at_bottom;

  for (genvar r = 0; r < WIN_ROWS; r++) begin : g_row
    bmorph_row_extend #(.W(W)) u_ext (
      .left_px_i   (nbr_left[r]),
      .right_px_i  (nbr_right[r]),
      .word_i      (rows[r]),
      .left_edge_i (at_left),
      .right_edge_i(at_right),
      .row_void_i  (row_void[r]),
      .pad_i       (pad0),
      .ext_o       (ext[r])
    );
  end

  bmorph_vreduce #(.N(EW)) u_vred (
    .op_i (op0),
    .up_i (ext[0]),
    .mid_i(ext[1]),
    .dn_i (ext[2]),
    .col_o(col0)
  );

  // ---------------- stage 1 registers ----------------
  logic          s1_valid_q, s1_valid_d;
  logic          s1_load;
  logic [EW-1:0] s1_col_q, s1_col_d;
  morph_op_e     s1_op_q, s1_op_d;

  always_comb begin
    s1_valid_d = in_valid;
    s1_load    = in_valid;
    s1_col_d   = col0;
    s1_op_d    = op0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) s1_valid_q <= 1'b0;
    else          s1_valid_q <= s1_valid_d;
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      s1_col_q <= s1_col_d;
      s1_op_q  <= s1_op_d;
    end
  end

  // ---------------- stage 1: horizontal reduce ----------------
  logic [W-1:0] px1;

  bmorph_hreduce #(.W(W)) u_hred (
    .op_i (s1_op_q),
    .col_i(s1_col_q),
    .px_o (px1)
  );

  // ---------------- output registers ----------------
  logic         o_valid_q, o_valid_d;
  logic         o_load;
  logic [W-1:0] o_word_q, o_word_d;

  always_comb begin
    o_valid_d = s1_valid_q;
    o_load    = s1_valid_q;
    o_word_d  = px1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) o_valid_q <= 1'b0;
    else          o_valid_q <= o_valid_d;
  end

  always_ff @(posedge clk) begin
    if (o_load) o_word_q <= o_word_d;
  end

  assign out_valid = o_valid_q;
  assign out_word  = o_word_q;

endmodule

// File: rtl/bmorph_engine_chk.sv
module bmorph_engine_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic         in_valid,
  input logic         in_dilate,
  input logic [W-1:0] row_up,
  input logic [W-1:0] row_mid,
  input logic [W-1:0] row_dn,
  input logic [2:0]   nbr_left,
  input logic [2:0]   nbr_right,
  input logic         out_valid,
  input logic [W-1:0] out_word
);

  // edges seen since the internal reset was released (saturating)
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)          seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (seen >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_erode_inside_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (seen >= 2'd2 && out_valid && !$past(in_dilate, 2))
      |-> ((out_word & ~$past(row_mid, 2)) == '0));

  p_dilate_cover_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (seen >= 2'd2 && out_valid && $past(in_dilate, 2))
      |-> ((~out_word & $past(row_mid, 2)) == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (seen >= 2'd1 && !out_valid) |-> $stable(out_word));

  // neutral padding: uniform neutral input yields uniform output, whatever the border flags
  p_erode_full_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !in_dilate && (&row_up) && (&row_mid) && (&row_dn)
      && (&nbr_left) && (&nbr_right)) |-> ##2 (&out_word));

  p_dilate_empty_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_dilate && row_up == '0 && row_mid == '0 && row_dn == '0
      && nbr_left == 3'b000 && nbr_right == 3'b000) |-> ##2 (out_word == '0));

endmodule

bind bmorph_engine bmorph_engine_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .in_valid (in_valid),
  .in_dilate(in_dilate),
  .row_up   (row_up),
  .row_mid  (row_mid),
  .row_dn   (row_dn),
  .nbr_left (nbr_left),
  .nbr_right(nbr_right),
  .out_valid(out_valid),
  .out_word (out_word)
);

// File: tb/bmorph_engine_test.sv
module bmorph_engine_test;

  localparam int unsigned BW     = 4;
  localparam time         PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_dilate;
  logic [BW-1:0] row_up, row_mid, row_dn;
  logic [2:0]    nbr_left, nbr_right;
  logic          at_left, at_right, at_top, at_bottom;
  logic          out_valid;
  logic [BW-1:0] out_word;

  int n_tests = 0;
  int n_fail  = 0;

  always #(PERIOD/2) clk = ~clk;

  bmorph_engine #(.W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dilate(in_dilate),
    .row_up(row_up), .row_mid(row_mid), .row_dn(row_dn),
    .nbr_left(nbr_left), .nbr_right(nbr_right),
    .at_left(at_left), .at_right(at_right), .at_top(at_top), .at_bottom(at_bottom),
    .out_valid(out_valid), .out_word(out_word)
  );

  // reference: 9-pixel window evaluated from the requirements
  function automatic logic [BW-1:0] model(
    input logic [BW-1:0] u, input logic [BW-1:0] m, input logic [BW-1:0] d,
    input logic [2:0] nl, input logic [2:0] nr,
    input logic el, input logic er, input logic et, input logic eb, input logic dil);
    logic [BW-1:0] res;
    logic          pad, acc, p;
    logic [BW-1:0] rw;
    pad = ~dil;
    for (int k = 0; k < BW; k++) begin
      acc = pad;
      for (int r = 0; r < 3; r++) begin
        rw = (r == 0) ? u : ((r == 1) ? m : d);
        for (int c = k - 1; c <= k + 1; c++) begin
          if ((r == 0 && et) || (r == 2 && eb)) p = pad;
          else if (c < 0)                       p = el ? pad : nl[r];
          else if (c >= BW)                     p = er ? pad : nr[r];
          else                                  p = rw[c];
          acc = dil ? (acc | p) : (acc & p);
        end
      end
      res[k] = acc;
    end
    return res;
  endfunction

  // two-deep expectation pipeline
  logic          d1_v, d2_v, have_last;
  logic [BW-1:0] d1_w, d2_w, last_w;
  string         d1_tag, d2_tag;

  task automatic check_out();
    n_tests++;
    if (d2_v) begin
      if (out_valid !== 1'b1 || out_word !== d2_w) begin
        n_fail++;
        $display("FAIL %s: out_valid=%b out_word=%b expected valid=1 word=%b",
                 d2_tag, out_valid, out_word, d2_w);
      end
      last_w    = d2_w;
      have_last = 1'b1;
    end else if (have_last) begin
      if (out_valid !== 1'b0 || out_word !== last_w) begin
        n_fail++;
        $display("FAIL R8: out_valid=%b out_word=%b expected valid=0 word=%b",
                 out_valid, out_word, last_w);
      end
    end else begin
      if (out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R9: out_valid=%b expected 0", out_valid);
      end
    end
  endtask

  task automatic tick(input string tag);
    d1_v   = in_valid;
    d1_w   = model(row_up, row_mid, row_dn, nbr_left, nbr_right,
                   at_left, at_right, at_top, at_bottom, in_dilate);
    d1_tag = tag;
    @(negedge clk);
    check_out();
    d2_v   = d1_v;
    d2_w   = d1_w;
    d2_tag = d1_tag;
  endtask

  task automatic drive(input logic v, input logic dil,
                       input logic [BW-1:0] u, input logic [BW-1:0] m, input logic [BW-1:0] d,
                       input logic [2:0] nl, input logic [2:0] nr,
                       input logic el, input logic er, input logic et, input logic eb,
                       input string tag);
    in_valid = v; in_dilate = dil;
    row_up = u; row_mid = m; row_dn = d;
    nbr_left = nl; nbr_right = nr;
    at_left = el; at_right = er; at_top = et; at_bottom = eb;
    tick(tag);
  endtask

  localparam logic [BW-1:0] ONES  = '1;
  localparam logic [BW-1:0] ZEROS = '0;

  initial begin
    d1_v = 1'b0; d2_v = 1'b0; have_last = 1'b0;
    d1_w = '0; d2_w = '0; last_w = '0;
    in_valid = 1'b0; in_dilate = 1'b0;
    row_up = '0; row_mid = '0; row_dn = '0;
    nbr_left = '0; nbr_right = '0;
    at_left = 1'b0; at_right = 1'b0; at_top = 1'b0; at_bottom = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: out_valid=%b during reset expected 0", out_valid);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) tick("R9");

    // R3: neighbour bits enter at bit 0 / bit W-1
    drive(1, 0, ONES, ONES, ONES, 3'b101, 3'b111, 0, 0, 0, 0, "R3");
    drive(1, 1, ZEROS, ZEROS, ZEROS, 3'b000, 3'b100, 0, 0, 0, 0, "R3");
    // R4: left neighbour ignored at left border
    drive(1, 0, ONES, ONES, ONES, 3'b000, 3'b111, 1, 0, 0, 0, "R4");
    drive(1, 1, ZEROS, ZEROS, ZEROS, 3'b111, 3'b000, 1, 0, 0, 0, "R4");
    // R5: right neighbour ignored at right border
    drive(1, 0, ONES, ONES, ONES, 3'b111, 3'b000, 0, 1, 0, 0, "R5");
    drive(1, 1, ZEROS, ZEROS, ZEROS, 3'b000, 3'b111, 0, 1, 0, 0, "R5");
    // R6: outer rows replaced at top and bottom
    drive(1, 0, ZEROS, ONES, ONES, 3'b110, 3'b110, 0, 0, 1, 0, "R6");
    drive(1, 1, ZEROS, ZEROS, ONES, 3'b100, 3'b100, 0, 0, 0, 1, "R6");
    drive(1, 0, 4'b1011, ONES, 4'b0111, 3'b010, 3'b010, 0, 0, 1, 1, "R6");
    // R7: lone beat then idles with changing inputs (R8 hold)
    drive(1, 1, 4'b0100, 4'b0000, 4'b0000, 3'b000, 3'b000, 0, 0, 0, 0, "R7");
    drive(0, 0, 4'b1111, 4'b1010, 4'b0101, 3'b011, 3'b101, 0, 0, 0, 0, "R8");
    drive(0, 1, 4'b0011, 4'b1100, 4'b1001, 3'b110, 3'b001, 1, 1, 1, 1, "R8");
    drive(0, 0, 4'b0110, 4'b0001, 4'b1110, 3'b000, 3'b111, 0, 1, 0, 1, "R8");

    // sweep: all three-row patterns in both modes, per-beat mode (R7)
    for (int i = 0; i < 8192; i++) begin
      logic [15:0] h;
      h = 16'(i * 40503) ^ 16'(i >> 2);
      if (i % 7 == 3)
        drive(0, h[0], ~row_up, h[3:0], h[7:4], h[2:0], h[5:3], h[6], h[7], h[8], h[9], "R8");
      drive(1, i[12], i[3:0], i[7:4], i[11:8], h[2:0], h[5:3],
            h[6] & h[10], h[7] & h[11], h[8] & h[12], h[9] & h[13],
            i[12] ? "R2" : "R1");
    end
    for (int k = 0; k < 3; k++)
      drive(0, 0, '0, '0, '0, '0, '0, 0, 0, 0, 0, "R8");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule